// File: doc/BRIEF.md
# DRAM Command Sequence Slot Scheduler

This block turns the short list of DRAM commands that one memory transaction needs (for instance close a row, open a row, then read) into a list of clock-cycle start times. Each start time meets the spacing rules that apply to that command. The caller supplies the command list, the bank it targets and an earliest start. The earliest start is given in sub-cycle units and the block aligns it to a clock edge. The caller also supplies, for every bank, the cycle of the most recent row-open and row-close, and the timing values in cycles. The block then produces the scheduled commands one per clock, in order, each with its start cycle. A done flag marks the last command.

Commands are chained: each one is proposed at the cycle where the previous one finishes its occupancy. Row-open commands are then moved later if the bank's open-to-open gap, close-to-open gap or the rolling open window would be broken. The window records the start cycles of the most recent row-opens issued by this block. Every command is also kept off a command-bus slot the block has already used. The block keeps that window and the last used bus slot across sequences, until reset.

Top module: `seq_cmd_sched`

## Requirements
- R1: The first command of an accepted sequence is proposed at the aligned earliest cycle. Every later command is proposed at the previous command's start plus its occupancy. With no constraint active, the start equals the proposal.
- R2: Occupancy uses the 3-bit command codes 0 close-row, 1 close-all, 2 open-row, 3 read, 4 read-with-close, 5 write, 6 write-with-close. Code 2 occupies `t_rcd` cycles, codes 0 and 1 occupy `t_rp` cycles, and codes 3 to 6 occupy BURST_CYC (default 8) cycles.
- R3: An open-row is delayed by the largest of two values. One is the excess of (the bank's last open + `t_aa`) over the proposal. The other is the excess of (the bank's last close + `t_rp`) over the proposal. Each excess counts as zero when it is not positive. For example, with a last open of 8 and a gap of 4, proposals 6, 8, 10, 12 and 14 start at 12, 12, 12, 12 and 14.
- R4: Once WIN_DEPTH open-rows have been issued since reset, an open-row cannot start before the oldest of the last WIN_DEPTH open starts plus `t_win`.
- R5: Start cycles issued since reset strictly increase. A slot at or before the last issued start is moved to the last issued start plus one. This move is applied after the R3/R4 delays.
- R6: `earliest_fine` counts 1/2^FRAC_BITS of a cycle. It is rounded up to a whole cycle, or rounded down when `round_down` is 1. With FRAC_BITS=1, a value of 5 gives 3 (up) or 2 (down).
- R7: A start taken while `ready` is high drops `ready` on the next cycle. Scheduled commands then appear one per cycle, starting two cycles after that start, with `out_done` high only on the last one. `ready` returns high in the cycle of the last command.
- R8: A `start` while `ready` is low, or with `seq_len` equal to 0, is ignored and produces no output.
- R9: After reset, `ready` is 1, `out_valid` and `out_done` are 0, and the window and the bus record are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to schedule a new sequence |
| seq_cmds | input | MAX_CMDS*3 | Command codes, entry i at bits [3i+2:3i] |
| seq_len | input | $clog2(MAX_CMDS+1) | Number of commands in the sequence |
| bank | input | $clog2(BANKS) | Bank targeted by the sequence |
| earliest_fine | input | 16 | Earliest start in sub-cycle units |
| round_down | input | 1 | 1 rounds the earliest start down instead of up |
| last_act_flat | input | BANKS*16 | Per-bank cycle of last open-row, bank b at bits [16b+15:16b] |
| last_pre_flat | input | BANKS*16 | Per-bank cycle of last close-row, same packing |
| t_rcd | input | TP_W | Open-row occupancy in cycles |
| t_rp | input | TP_W | Close-row occupancy and close-to-open gap |
| t_aa | input | TP_W | Open-to-open gap for one bank |
| t_win | input | TP_W | Span of the rolling open window |
| ready | output | 1 | Idle, able to take a sequence |
| out_valid | output | 1 | A scheduled command is presented |
| out_cmd | output | 3 | Code of the scheduled command |
| out_time | output | 16 | Start cycle of the scheduled command |
| out_done | output | 1 | The presented command is the last of the sequence |

## Verification
The bench uses the default parameters: four commands per sequence, four banks, a window of depth four and one fractional bit on the earliest start. A window of depth four fills after four single open-row sequences, so the fifth and sixth are pushed out by the window span, and the bus-slot bump appears while the window fills. One fractional bit gives both exact and half-cycle earliest values, so both rounding directions are observable. A four-entry sequence exercises every occupancy class in one chain.

// File: rtl/seqsched_pkg.sv
package seqsched_pkg;

  parameter int unsigned TIME_W = 16;
  parameter int unsigned CMD_W  = 3;

  typedef logic [TIME_W-1:0] cyc_t;

  typedef enum logic [CMD_W-1:0] {
    CMD_CLOSE     = 3'd0,
    CMD_CLOSE_ALL = 3'd1,
    CMD_OPEN      = 3'd2,
    CMD_RD        = 3'd3,
    CMD_RD_CL     = 3'd4,
    CMD_WR        = 3'd5,
    CMD_WR_CL     = 3'd6,
    CMD_NONE      = 3'd7
  } cmd_e;

  // Excess of (prev + gap) over at; zero when not positive.
  function automatic cyc_t delay_by(cyc_t prev, cyc_t at, cyc_t gap);
    logic [TIME_W:0] lim;
    lim = {1'b0, prev} + {1'b0, gap};
    if (lim > {1'b0, at}) return cyc_t'(lim - {1'b0, at});
    return '0;
  endfunction

  function automatic cyc_t max3(cyc_t a, cyc_t b, cyc_t c);
    cyc_t m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  // Sub-cycle time to whole cycles.
  function automatic cyc_t to_cycles(cyc_t fine, int unsigned frac, logic down);
    cyc_t whole;
    cyc_t mask;
    whole = fine >> frac;
    mask  = (cyc_t'(1) << frac) - cyc_t'(1);
    if (!down && ((fine & mask) != '0)) whole = whole + cyc_t'(1);
    return whole;
  endfunction

  function automatic cyc_t occupancy(cmd_e c, cyc_t rcd, cyc_t rp, cyc_t burst);
    case (c)
      CMD_OPEN:                 return rcd;
      CMD_CLOSE, CMD_CLOSE_ALL: return rp;
      default:                  return burst;
    endcase
  endfunction

endpackage

// File: rtl/seqsched_actwin.sv
module seqsched_actwin
  import seqsched_pkg::*;
#(
  parameter int unsigned DEPTH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic push,
  input  cyc_t din,
  output cyc_t oldest,
  output logic full
);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  cyc_t             hist [DEPTH];
  logic [CNT_W-1:0] fill_q;

  // Shift history: newest at DEPTH-1, oldest of a full window at 0.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill_q <= '0;
      for (int k = 0; k < DEPTH; k++) hist[k] <= '0;
    end else if (push) begin
      if (fill_q != CNT_W'(DEPTH)) fill_q <= fill_q + 1'b1;
      for (int k = 0; k < DEPTH - 1; k++) hist[k] <= hist[k+1];
      hist[DEPTH-1] <= din;
    end
  end

  assign full   = (fill_q == CNT_W'(DEPTH));
  assign oldest = hist[0];

endmodule

// File: rtl/seqsched_slot.sv
module seqsched_slot
  import seqsched_pkg::*;
#(
  parameter int unsigned TP_W      = 8,
  parameter int unsigned BURST_CYC = 8
) (
  input  cmd_e            cmd,
  input  cyc_t            proposed,
  input  cyc_t            bank_last_open,
  input  cyc_t            bank_last_close,
  input  logic            win_full,
  input  cyc_t            win_oldest,
  input  logic            bus_used,
  input  cyc_t            bus_last,
  input  logic [TP_W-1:0] t_rcd,
  input  logic [TP_W-1:0] t_rp,
  input  logic [TP_W-1:0] t_aa,
  input  logic [TP_W-1:0] t_win,
  output cyc_t            slot,
  output cyc_t            occ,
  output logic            bus_bump,
  output logic            win_limit
);
  logic is_open;
  cyc_t d_gap, d_close, d_win, worst, cand;

  assign is_open = (cmd == CMD_OPEN);

  always_comb begin
    d_gap   = '0;
    d_close = '0;
    d_win   = '0;
    if (is_open) begin
      d_gap   = delay_by(bank_last_open, proposed, cyc_t'(t_aa));
      d_close = delay_by(bank_last_close, proposed, cyc_t'(t_rp));
      if (win_full) d_win = delay_by(win_oldest, proposed, cyc_t'(t_win));
    end
    worst = max3(d_gap, d_close, d_win);
    cand  = proposed + worst;
  end

  assign win_limit = is_open && win_full && (d_win != '0);
  assign bus_bump  = bus_used && (cand <= bus_last);
  assign slot      = bus_bump ? (bus_last + cyc_t'(1)) : cand;
  assign occ       = occupancy(cmd, cyc_t'(t_rcd), cyc_t'(t_rp), cyc_t'(BURST_CYC));

endmodule

// File: rtl/seq_cmd_sched.sv
module seq_cmd_sched
  import seqsched_pkg::*;
#(
  parameter int unsigned MAX_CMDS  = 4,
  parameter int unsigned BANKS     = 4,
  parameter int unsigned WIN_DEPTH = 4,
  parameter int unsigned FRAC_BITS = 1,
  parameter int unsigned TP_W      = 8,
  parameter int unsigned BURST_CYC = 8,
  localparam int unsigned LEN_W    = $clog2(MAX_CMDS + 1),
  localparam int unsigned BANK_W   = (BANKS > 1) ? $clog2(BANKS) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic [MAX_CMDS*CMD_W-1:0]  seq_cmds,
  input  logic [LEN_W-1:0]           seq_len,
  input  logic [BANK_W-1:0]          bank,
  input  logic [TIME_W-1:0]          earliest_fine,
  input  logic                       round_down,
  input  logic [BANKS*TIME_W-1:0]    last_act_flat,
  input  logic [BANKS*TIME_W-1:0]    last_pre_flat,
  input  logic [TP_W-1:0]            t_rcd,
  input  logic [TP_W-1:0]            t_rp,
  input  logic [TP_W-1:0]            t_aa,
  input  logic [TP_W-1:0]            t_win,
  output logic                       ready,
  output logic                       out_valid,
  output logic [CMD_W-1:0]           out_cmd,
  output logic [TIME_W-1:0]          out_time,
  output logic                       out_done
);
  localparam int unsigned IDX_W = (MAX_CMDS > 1) ? $clog2(MAX_CMDS) : 1;

  cyc_t open_tab  [BANKS];
  cyc_t close_tab [BANKS];

  for (genvar b = 0; b < BANKS; b++) begin : g_bank_unpack
    assign open_tab[b]  = last_act_flat[b*TIME_W +: TIME_W];
    assign close_tab[b] = last_pre_flat[b*TIME_W +: TIME_W];
  end

  logic              busy_q;
  logic [IDX_W-1:0]  idx_q;
  logic [LEN_W-1:0]  len_q;
  logic [BANK_W-1:0] bank_q;
  cmd_e              cmds_q [MAX_CMDS];
  cyc_t              early_q;
  cyc_t              prev_end_q;
  logic              bus_used_q;
  cyc_t              bus_last_q;

  // Named internal events.
  logic accept, step, last_step, open_issue, bus_bump, win_limit, win_full;
  cmd_e cur_cmd;
  cyc_t proposed, slot, occ, win_oldest;
  logic [LEN_W-1:0] len_in;

  assign len_in     = (seq_len > LEN_W'(MAX_CMDS)) ? LEN_W'(MAX_CMDS) : seq_len;
  assign accept     = !busy_q && start && (seq_len != '0);
  assign step       = busy_q;
  assign cur_cmd    = cmds_q[idx_q];
  assign last_step  = step && (LEN_W'(idx_q) == len_q - 1'b1);
  assign open_issue = step && (cur_cmd == CMD_OPEN);
  assign proposed   = (idx_q == '0) ? early_q : prev_end_q;

  seqsched_actwin #(.DEPTH(WIN_DEPTH)) u_win (
    .clk    (clk),
    .rst_n  (rst_n),
    .push   (open_issue),
    .din    (slot),
    .oldest (win_oldest),
    .full   (win_full)
  );

  seqsched_slot #(.TP_W(TP_W), .BURST_CYC(BURST_CYC)) u_slot (
    .cmd             (cur_cmd),
    .proposed        (proposed),
    .bank_last_open  (open_tab[bank_q]),
    .bank_last_close (close_tab[bank_q]),
    .win_full        (win_full),
    .win_oldest      (win_oldest),
    .bus_used        (bus_used_q),
    .bus_last        (bus_last_q),
    .t_rcd           (t_rcd),
    .t_rp            (t_rp),
    .t_aa            (t_aa),
    .t_win           (t_win),
    .slot            (slot),
    .occ             (occ),
    .bus_bump        (bus_bump),
    .win_limit       (win_limit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      idx_q      <= '0;
      len_q      <= '0;
      bank_q     <= '0;
      early_q    <= '0;
      prev_end_q <= '0;
      bus_used_q <= 1'b0;
      bus_last_q <= '0;
      out_valid  <= 1'b0;
      out_done   <= 1'b0;
      out_cmd    <= '0;
      out_time   <= '0;
      for (int k = 0; k < MAX_CMDS; k++) cmds_q[k] <= CMD_NONE;
    end else begin
      out_valid <= 1'b0;
      out_done  <= 1'b0;
      if (accept) begin
        busy_q  <= 1'b1;
        idx_q   <= '0;
        len_q   <= len_in;
        bank_q  <= bank;
        early_q <= to_cycles(earliest_fine, FRAC_BITS, round_down);
        for (int k = 0; k < MAX_CMDS; k++)
          cmds_q[k] <= cmd_e'(seq_cmds[k*CMD_W +: CMD_W]);
      end else if (step) begin
        out_valid  <= 1'b1;
        out_cmd    <= cur_cmd;
        out_time   <= slot;
        out_done   <= last_step;
        prev_end_q <= slot + occ;
        bus_used_q <= 1'b1;
        bus_last_q <= slot;
        idx_q      <= idx_q + 1'b1;
        if (last_step) busy_q <= 1'b0;
      end
    end
  end

  assign ready = !busy_q;

endmodule

// File: rtl/seqsched_chk.sv
module seqsched_chk
  import seqsched_pkg::*;
#(
  parameter int unsigned LEN_W = 3,
  parameter int unsigned TP_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [LEN_W-1:0]  seq_len,
  input logic              ready,
  input logic              out_valid,
  input logic [CMD_W-1:0]  out_cmd,
  input logic [TIME_W-1:0] out_time,
  input logic              out_done,
  input logic [TP_W-1:0]   t_rcd
);
  logic seen_q;
  cyc_t last_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      last_q <= '0;
    end else if (out_valid) begin
      seen_q <= 1'b1;
      last_q <= out_time;
    end
  end

  assert_done_has_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_done |-> out_valid);

  assert_accept_goes_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && start && (seq_len != '0)) |=> (!ready && !out_valid));

  assert_idle_ignores_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !(start && (seq_len != '0))) |=> (ready && !out_valid));

  assert_bus_increasing_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && seen_q) |-> (out_time > last_q));

  assert_open_occupancy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(out_valid) && !$past(out_done) && ($past(out_cmd) == CMD_OPEN))
      |-> (out_time >= $past(out_time) + cyc_t'(t_rcd)));

endmodule

bind seq_cmd_sched seqsched_chk #(.LEN_W(LEN_W), .TP_W(TP_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .seq_len   (seq_len),
  .ready     (ready),
  .out_valid (out_valid),
  .out_cmd   (out_cmd),
  .out_time  (out_time),
  .out_done  (out_done),
  .t_rcd     (t_rcd)
);

// File: tb/seq_cmd_sched_test.sv
`timescale 1ns/1ps
module seq_cmd_sched_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [11:0] seq_cmds = '0;
  logic [2:0]  seq_len = '0;
  logic [1:0]  bank = '0;
  logic [15:0] earliest_fine = '0;
  logic        round_down = 1'b0;
  logic [63:0] last_act_flat = '0;
  logic [63:0] last_pre_flat = '0;
  logic [7:0]  t_rcd = 8'd3, t_rp = 8'd3, t_aa = 8'd4, t_win = 8'd20;
  logic        ready, out_valid, out_done;
  logic [2:0]  out_cmd;
  logic [15:0] out_time;

  int n_run = 0, n_fail = 0;
  bit finished = 0;
  logic [15:0] got_t [4];
  logic [2:0]  got_c [4];

  always #4 clk = ~clk;

  seq_cmd_sched uut (
    .clk(clk), .rst_n(rst_n), .start(start), .seq_cmds(seq_cmds), .seq_len(seq_len),
    .bank(bank), .earliest_fine(earliest_fine), .round_down(round_down),
    .last_act_flat(last_act_flat), .last_pre_flat(last_pre_flat),
    .t_rcd(t_rcd), .t_rp(t_rp), .t_aa(t_aa), .t_win(t_win),
    .ready(ready), .out_valid(out_valid), .out_cmd(out_cmd), .out_time(out_time),
    .out_done(out_done)
  );

  typedef struct packed {
    logic [11:0] cmds;
    logic [2:0]  len;
    logic [1:0]  bnk;
    logic [15:0] fine;
    logic        rdown;
    logic [15:0] lact;
    logic [15:0] lpre;
    logic [63:0] exp_t;
  } vec_t;

  // Command codes: 0 close, 1 close-all, 2 open, 3 rd, 4 rd+close, 5 wr, 6 wr+close.
  localparam vec_t VECS [11] = '{
    '{{3'd0,3'd3,3'd2,3'd0}, 3'd3, 2'd0, 16'd20, 1'b0, 16'd0,  16'd0,  {16'd0,16'd16,16'd13,16'd10}},
    '{{3'd0,3'd0,3'd5,3'd2}, 3'd2, 2'd1, 16'd5,  1'b0, 16'd5,  16'd2,  {16'd0,16'd0,16'd12,16'd9}},
    '{{3'd0,3'd0,3'd4,3'd2}, 3'd2, 2'd2, 16'd5,  1'b1, 16'd1,  16'd6,  {16'd0,16'd0,16'd12,16'd9}},
    '{{3'd2,3'd1,3'd6,3'd5}, 3'd4, 2'd3, 16'd0,  1'b0, 16'd0,  16'd0,  {16'd19,16'd16,16'd8,16'd0}},
    '{{3'd0,3'd0,3'd0,3'd2}, 3'd1, 2'd0, 16'd40, 1'b0, 16'd18, 16'd19, {48'd0,16'd22}},
    '{{3'd0,3'd0,3'd0,3'd3}, 3'd1, 2'd0, 16'd7,  1'b0, 16'd0,  16'd0,  {48'd0,16'd4}},
    '{{3'd0,3'd0,3'd0,3'd2}, 3'd1, 2'd1, 16'd20, 1'b0, 16'd8,  16'd0,  {48'd0,16'd12}},
    '{{3'd0,3'd0,3'd0,3'd2}, 3'd1, 2'd1, 16'd16, 1'b0, 16'd8,  16'd0,  {48'd0,16'd12}},
    '{{3'd0,3'd0,3'd0,3'd2}, 3'd1, 2'd1, 16'd12, 1'b0, 16'd8,  16'd0,  {48'd0,16'd12}},
    '{{3'd0,3'd0,3'd0,3'd2}, 3'd1, 2'd1, 16'd24, 1'b0, 16'd8,  16'd0,  {48'd0,16'd12}},
    '{{3'd0,3'd0,3'd0,3'd2}, 3'd1, 2'd1, 16'd28, 1'b0, 16'd8,  16'd0,  {48'd0,16'd14}}
  };

  task automatic chk(input string req, input int got, input int expv);
    n_run++;
    if (got !== expv) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, got, expv);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    start = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic drive_seq(input logic [11:0] c, input logic [2:0] n, input logic [1:0] b,
                           input logic [15:0] f, input logic rd,
                           input logic [15:0] la, input logic [15:0] lp);
    seq_cmds = c; seq_len = n; bank = b; earliest_fine = f; round_down = rd;
    for (int bb = 0; bb < 4; bb++) begin
      last_act_flat[bb*16 +: 16] = (bb == int'(b)) ? la : 16'd1000;
      last_pre_flat[bb*16 +: 16] = (bb == int'(b)) ? lp : 16'd1000;
    end
  endtask

  task automatic run_seq(input logic [11:0] c, input logic [2:0] n, input logic [1:0] b,
                         input logic [15:0] f, input logic rd,
                         input logic [15:0] la, input logic [15:0] lp);
    @(negedge clk);
    drive_seq(c, n, b, f, rd, la, lp);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R7 ready low after accept", int'(ready), 0);
    for (int j = 0; j < int'(n); j++) begin
      @(negedge clk);
      chk("R7 one command per cycle", int'(out_valid), 1);
      chk("R7 done on last only", int'(out_done), (j == int'(n) - 1) ? 1 : 0);
      got_t[j] = out_time;
      got_c[j] = out_cmd;
    end
    chk("R7 ready back with last command", int'(ready), 1);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    // R9 reset state
    do_reset();
    @(negedge clk);
    chk("R9 ready after reset", int'(ready), 1);
    chk("R9 no valid after reset", int'(out_valid), 0);
    chk("R9 no done after reset", int'(out_done), 0);

    // Table: R1 R2 R3 R6 start cycles, each row from reset
    for (int v = 0; v < 11; v++) begin
      do_reset();
      run_seq(VECS[v].cmds, VECS[v].len, VECS[v].bnk, VECS[v].fine, VECS[v].rdown,
              VECS[v].lact, VECS[v].lpre);
      for (int j = 0; j < int'(VECS[v].len); j++) begin
        chk("R1 R2 R3 R6 start cycle", int'(got_t[j]), int'(VECS[v].exp_t[j*16 +: 16]));
        chk("R1 command order", int'(got_c[j]), int'(VECS[v].cmds[j*3 +: 3]));
      end
    end

    // R4 window and R5 bus bump across sequences
    do_reset();
    run_seq(12'd2, 3'd1, 2'd0, 16'd0, 1'b0, 16'd0, 16'd0);
    chk("R3 first open", int'(got_t[0]), 4);
    run_seq(12'd2, 3'd1, 2'd0, 16'd0, 1'b0, 16'd0, 16'd0);
    chk("R5 bus bump", int'(got_t[0]), 5);
    run_seq(12'd2, 3'd1, 2'd0, 16'd0, 1'b0, 16'd0, 16'd0);
    chk("R5 bus bump", int'(got_t[0]), 6);
    run_seq(12'd2, 3'd1, 2'd0, 16'd0, 1'b0, 16'd0, 16'd0);
    chk("R5 bus bump", int'(got_t[0]), 7);
    run_seq(12'd2, 3'd1, 2'd0, 16'd0, 1'b0, 16'd0, 16'd0);
    chk("R4 window oldest 4", int'(got_t[0]), 24);
    run_seq(12'd2, 3'd1, 2'd0, 16'd0, 1'b0, 16'd0, 16'd0);
    chk("R4 window oldest 5", int'(got_t[0]), 25);
    run_seq(12'd3, 3'd1, 2'd0, 16'd20, 1'b0, 16'd0, 16'd0);
    chk("R5 read bumped past bus", int'(got_t[0]), 26);

    // R8 zero length ignored
    @(negedge clk);
    drive_seq(12'd3, 3'd0, 2'd0, 16'd100, 1'b0, 16'd0, 16'd0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 4; k++) begin
      chk("R8 zero length keeps ready", int'(ready), 1);
      chk("R8 zero length no output", int'(out_valid), 0);
      @(negedge clk);
    end

    // R8 start while busy ignored
    drive_seq({3'd0, 3'd0, 3'd3, 3'd3}, 3'd2, 2'd0, 16'd60, 1'b0, 16'd0, 16'd0);
    start = 1'b1;
    @(negedge clk);
    drive_seq(12'd2, 3'd1, 2'd0, 16'd0, 1'b0, 16'd0, 16'd0);
    start = 1'b1;
    chk("R8 busy at second start", int'(ready), 0);
    @(negedge clk);
    start = 1'b0;
    chk("R8 first read", int'(out_time), 30);
    @(negedge clk);
    chk("R2 read occupancy 8", int'(out_time), 38);
    chk("R7 done on second", int'(out_done), 1);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R8 busy start dropped", int'(out_valid), 0);
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule